// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Flush Unit

This block is the control unit that keeps a five-stage in-order integer pipeline correct when there is no operand bypass network. The stages are fetch, decode/register read, execute, memory and write-back, in that order, with a stage buffer between each adjacent pair. Every cycle the unit compares the source registers of the instruction in decode with the write-enabled destinations of the instructions in execute, memory and write-back. It then picks one of three front-end actions: run, stall, or flush.

On a read-after-write hazard it holds the program counter and the fetch buffer and loads a no-op into the decode-to-execute buffer. The older instructions keep moving, so a dependent reader is released only after its producer has left write-back. A conditional branch resolves in execute. When the branch is taken, the unit squashes the two younger instructions in the fetch and decode buffers and strobes a redirect so that fetch resumes at the target. The unit is purely combinational. Its clock and reset inputs only qualify the bound property checks.

Top module: `hzd_unit`

## Requirements
- R1: `hold_front` is 1 in any cycle where a valid decode source matches the destination of a valid, write-enabled instruction in execute, memory or write-back, unless a taken branch is in execute.
- R2: While stalled, `insert_bubble` is 1 together with `hold_front`, and neither squash output is raised.
- R3: With `ZERO_HW`=1, a source of index 0 never causes a stall, even if an older instruction names register 0 as its destination.
- R4: Invalid decode sources, invalid stage slots and stage slots with write enable 0 never cause a stall. With all slots idle, every output is 0.
- R5: When `br_vld` and `br_taken` are both 1, `squash_fetch`, `squash_decode` and `redirect` are all 1 in that same cycle.
- R6: A taken branch overrides a simultaneous data hazard. In that cycle `hold_front` and `insert_bubble` are 0.
- R7: Without a taken branch in execute (no branch, or a not-taken one), `squash_fetch`, `squash_decode` and `redirect` stay 0, and the following instruction enters execute with no gap.
- R8: A reader that is one, two or three instructions behind its producer is stalled for 3, 2 or 1 cycles respectively. At a distance of four or more, or with no shared register, it is not stalled.
- R9: A taken branch leaves exactly two no-op slots between the branch and its target at write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the bound checks |
| rst | input | 1 | Synchronous active-high reset for the bound checks |
| dec_src_vld | input | NUM_SRC | Per-source valid of the decode-stage instruction |
| dec_src_idx | input | NUM_SRC x REG_W | Decode-stage source register indices |
| stg_vld | input | NUM_STG | Slot valid per downstream stage; bit 0 execute, bit 1 memory, bit 2 write-back |
| stg_wen | input | NUM_STG | Register write enable per downstream stage, same bit order |
| stg_dst | input | NUM_STG x REG_W | Destination register per downstream stage, same order |
| br_vld | input | 1 | A conditional branch occupies execute |
| br_taken | input | 1 | Outcome of that branch; 1 = taken |
| hold_front | output | 1 | Hold the PC and the fetch buffer |
| insert_bubble | output | 1 | Load a no-op into the decode-to-execute buffer for a stall |
| squash_fetch | output | 1 | Replace the fetch buffer contents with a no-op |
| squash_decode | output | 1 | Replace the instruction leaving decode with a no-op |
| redirect | output | 1 | Load the branch target into the PC |

## Verification
The bound properties check, on every cycle, the relations that can be read from a single cycle: a match in execute forces a stall, a stall always comes with a bubble, a taken branch raises all three flush outputs and masks the stall, squashes never appear without a taken branch, and zero-index or producer-free cycles stay quiet. The stall lengths at each dependency distance, the zero-cost independent and not-taken sequences, and the two-slot gap after a taken branch are multi-cycle results. Only the bench scenarios can show these, because the bench drives its pipeline model with the unit's own outputs and measures the stall count and the retirement order.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Bit positions of the downstream stages inside the per-stage vectors.
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;

    // Front-end action chosen each cycle.
    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_STALL = 2'd1,
        ACT_FLUSH = 2'd2
    } front_act_e;

    // Control bundle handed to the stage buffers.
    typedef struct packed {
        logic hold;
        logic bubble;
        logic sq_fetch;
        logic sq_decode;
        logic redirect;
    } front_ctl_t;

    function automatic front_ctl_t act_to_ctl(front_act_e act);
        front_ctl_t c;
        c = '0;
        case (act)
            ACT_STALL: begin
                c.hold   = 1'b1;
                c.bubble = 1'b1;
            end
            ACT_FLUSH: begin
                c.sq_fetch  = 1'b1;
                c.sq_decode = 1'b1;
                c.redirect  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
// Compares one decode-stage source against every downstream producer.
module hzd_src_cmp #(
    parameter int REG_W   = 5,
    parameter int N_STG   = 3,
    parameter bit ZERO_HW = 1'b1
) (
    input  logic                        src_vld,
    input  logic [REG_W-1:0]            src_idx,
    input  logic [N_STG-1:0]            stg_vld,
    input  logic [N_STG-1:0]            stg_wen,
    input  logic [N_STG-1:0][REG_W-1:0] stg_dst,
    output logic                        hit
);
    logic             src_live;
    logic [N_STG-1:0] stage_match;

    generate
        if (ZERO_HW) begin : g_zero_filter
            assign src_live = src_vld && (src_idx != '0);
        end else begin : g_no_filter
            assign src_live = src_vld;
        end
    endgenerate

    genvar g;
    generate
        for (g = 0; g < N_STG; g++) begin : g_stage
            assign stage_match[g] = stg_vld[g] && stg_wen[g] && (stg_dst[g] == src_idx);
        end
    endgenerate

    assign hit = src_live && (|stage_match);
endmodule

// File: rtl/hzd_front_arb.sv
// Picks the front-end action; a taken branch beats a data hazard.
module hzd_front_arb
    import hzd_pkg::*;
(
    input  logic       raw_hazard,
    input  logic       br_vld,
    input  logic       br_taken,
    output front_act_e act
);
    always_comb begin
        if (br_vld && br_taken) begin
            act = ACT_FLUSH;
        end else if (raw_hazard) begin
            act = ACT_STALL;
        end else begin
            act = ACT_RUN;
        end
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int NUM_STG = 3,
    parameter bit ZERO_HW = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            dec_src_vld,
    input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src_idx,
    input  logic [NUM_STG-1:0]            stg_vld,
    input  logic [NUM_STG-1:0]            stg_wen,
    input  logic [NUM_STG-1:0][REG_W-1:0] stg_dst,
    input  logic                          br_vld,
    input  logic                          br_taken,
    output logic                          hold_front,
    output logic                          insert_bubble,
    output logic                          squash_fetch,
    output logic                          squash_decode,
    output logic                          redirect
);
    logic [NUM_SRC-1:0] src_hit;
    logic               raw_hazard;
    front_act_e         act;
    front_ctl_t         ctl;

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            hzd_src_cmp #(
                .REG_W  (REG_W),
                .N_STG  (NUM_STG),
                .ZERO_HW(ZERO_HW)
            ) u_cmp (
                .src_vld (dec_src_vld[s]),
                .src_idx (dec_src_idx[s]),
                .stg_vld (stg_vld),
                .stg_wen (stg_wen),
                .stg_dst (stg_dst),
                .hit     (src_hit[s])
            );
        end
    endgenerate

    assign raw_hazard = |src_hit;

    hzd_front_arb u_arb (
        .raw_hazard (raw_hazard),
        .br_vld     (br_vld),
        .br_taken   (br_taken),
        .act        (act)
    );

    assign ctl           = act_to_ctl(act);
    assign hold_front    = ctl.hold;
    assign insert_bubble = ctl.bubble;
    assign squash_fetch  = ctl.sq_fetch;
    assign squash_decode = ctl.sq_decode;
    assign redirect      = ctl.redirect;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2,
    parameter int NUM_STG = 3,
    parameter bit ZERO_HW = 1'b1
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_SRC-1:0]            dec_src_vld,
    input logic [NUM_SRC-1:0][REG_W-1:0] dec_src_idx,
    input logic [NUM_STG-1:0]            stg_vld,
    input logic [NUM_STG-1:0]            stg_wen,
    input logic [NUM_STG-1:0][REG_W-1:0] stg_dst,
    input logic                          br_vld,
    input logic                          br_taken,
    input logic                          hold_front,
    input logic                          insert_bubble,
    input logic                          squash_fetch,
    input logic                          squash_decode,
    input logic                          redirect
);
    logic any_live_src;
    logic ex_match;
    logic taken;

    always_comb begin
        any_live_src = 1'b0;
        ex_match     = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (dec_src_vld[i] && (!ZERO_HW || dec_src_idx[i] != '0)) begin
                any_live_src = 1'b1;
                if (stg_vld[0] && stg_wen[0] && stg_dst[0] == dec_src_idx[i]) begin
                    ex_match = 1'b1;
                end
            end
        end
    end

    assign taken = br_vld && br_taken;

    a_r1_ex_match_stalls: assert property (@(posedge clk) disable iff (rst)
        (ex_match && !taken) |-> hold_front);

    a_r2_stall_with_bubble: assert property (@(posedge clk) disable iff (rst)
        hold_front |-> (insert_bubble && !squash_fetch && !squash_decode));

    a_r3_zero_src_quiet: assert property (@(posedge clk) disable iff (rst)
        !any_live_src |-> !hold_front);

    a_r4_no_producer_quiet: assert property (@(posedge clk) disable iff (rst)
        ((stg_vld & stg_wen) == '0) |-> !hold_front);

    a_r5_taken_flushes: assert property (@(posedge clk) disable iff (rst)
        taken |-> (squash_fetch && squash_decode && redirect));

    a_r6_flush_masks_stall: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (!hold_front && !insert_bubble));

    a_r7_no_spurious_flush: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (!redirect && !squash_fetch && !squash_decode));

    a_r2_one_action: assert property (@(posedge clk) disable iff (rst)
        $countones({hold_front, redirect}) <= 1);
endmodule

bind hzd_unit hzd_unit_chk #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC),
    .NUM_STG(NUM_STG),
    .ZERO_HW(ZERO_HW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dec_src_vld  (dec_src_vld),
    .dec_src_idx  (dec_src_idx),
    .stg_vld      (stg_vld),
    .stg_wen      (stg_wen),
    .stg_dst      (stg_dst),
    .br_vld       (br_vld),
    .br_taken     (br_taken),
    .hold_front   (hold_front),
    .insert_bubble(insert_bubble),
    .squash_fetch (squash_fetch),
    .squash_decode(squash_decode),
    .redirect     (redirect)
);

// File: tb/test_hzd_unit.sv
`timescale 1ns/1ps
module test_hzd_unit;
    localparam int RW = 5;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          dec_src_vld = '0;
    logic [1:0][RW-1:0]  dec_src_idx = '0;
    logic [2:0]          stg_vld = '0;
    logic [2:0]          stg_wen = '0;
    logic [2:0][RW-1:0]  stg_dst = '0;
    logic                br_vld = 1'b0;
    logic                br_taken = 1'b0;
    logic hold_front, insert_bubble, squash_fetch, squash_decode, redirect;

    always #2 clk = ~clk;

    hzd_unit i_hzd_unit (
        .clk(clk), .rst(rst),
        .dec_src_vld(dec_src_vld), .dec_src_idx(dec_src_idx),
        .stg_vld(stg_vld), .stg_wen(stg_wen), .stg_dst(stg_dst),
        .br_vld(br_vld), .br_taken(br_taken),
        .hold_front(hold_front), .insert_bubble(insert_bubble),
        .squash_fetch(squash_fetch), .squash_decode(squash_decode),
        .redirect(redirect)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Program store: kind 0 = no-op, 1 = ALU writer, 2 = conditional branch.
    int p_kind[16], p_dst[16], p_s1[16], p_s2[16], p_tk[16], p_tgt[16];
    // Slots: 0 fetch buffer, 1 execute, 2 memory, 3 write-back; -1 = no-op.
    int slot[4];
    int pc;
    int stall_cnt;
    int retire_q[$];

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int kind_of(int id);
        return (id < 0) ? 0 : p_kind[id];
    endfunction

    function automatic int fetch_at(int a);
        if (a < 0 || a > 15) return -1;
        return (p_kind[a] == 0) ? -1 : a;
    endfunction

    function automatic bit model_hazard();
        int id;
        int srcs[2];
        id = slot[0];
        if (id < 0) return 0;
        srcs[0] = p_s1[id];
        srcs[1] = p_s2[id];
        foreach (srcs[j]) begin
            if (srcs[j] != 0) begin
                for (int k = 1; k < 4; k++) begin
                    if (kind_of(slot[k]) == 1 && p_dst[slot[k]] == srcs[j]) return 1;
                end
            end
        end
        return 0;
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) begin
            p_kind[i] = 0; p_dst[i] = 0; p_s1[i] = 0;
            p_s2[i] = 0; p_tk[i] = 0; p_tgt[i] = 0;
        end
    endtask

    task automatic set_ins(int a, int k, int d, int s1, int s2, int tk, int tgt);
        p_kind[a] = k; p_dst[a] = d; p_s1[a] = s1;
        p_s2[a] = s2; p_tk[a] = tk; p_tgt[a] = tgt;
    endtask

    task automatic step();
        bit e_tk, e_hz, e_stall;
        logic o_hold, o_bub, o_sf, o_sd, o_red;
        int old_ex, new_ex, new_fb;
        @(negedge clk);
        dec_src_vld    = (slot[0] >= 0) ? 2'b11 : 2'b00;
        dec_src_idx[0] = (slot[0] >= 0) ? RW'(p_s1[slot[0]]) : '0;
        dec_src_idx[1] = (slot[0] >= 0) ? RW'(p_s2[slot[0]]) : '0;
        for (int k = 1; k < 4; k++) begin
            stg_vld[k-1] = (slot[k] >= 0);
            stg_wen[k-1] = (kind_of(slot[k]) == 1);
            stg_dst[k-1] = (slot[k] >= 0) ? RW'(p_dst[slot[k]]) : '0;
        end
        br_vld   = (kind_of(slot[1]) == 2);
        br_taken = br_vld && (p_tk[slot[1]] != 0);
        #1;
        e_tk    = br_vld && br_taken;
        e_hz    = model_hazard();
        e_stall = e_hz && !e_tk;
        o_hold = hold_front; o_bub = insert_bubble; o_sf = squash_fetch;
        o_sd = squash_decode; o_red = redirect;
        chk((e_hz && e_tk) ? "R6 hold_front" : "R1 hold_front", o_hold, e_stall);
        chk((e_hz && e_tk) ? "R6 insert_bubble" : "R2 insert_bubble", o_bub, e_stall);
        chk(e_tk ? "R5 squash_fetch" : "R7 squash_fetch", o_sf, e_tk);
        chk(e_tk ? "R5 squash_decode" : "R7 squash_decode", o_sd, e_tk);
        chk(e_tk ? "R5 redirect" : "R7 redirect", o_red, e_tk);
        retire_q.push_back(slot[3]);
        if (o_hold) stall_cnt++;
        // Advance the pipeline model under the unit's own controls.
        old_ex = slot[1];
        new_ex = (o_sd || o_bub) ? -1 : slot[0];
        new_fb = o_sf ? -1 : (o_hold ? slot[0] : fetch_at(pc));
        slot[3] = slot[2];
        slot[2] = old_ex;
        slot[1] = new_ex;
        slot[0] = new_fb;
        if (o_red) pc = (old_ex >= 0) ? p_tgt[old_ex] : pc;
        else if (!o_hold) pc = pc + 1;
    endtask

    task automatic run_prog(int n);
        for (int k = 0; k < 4; k++) slot[k] = -1;
        pc = 0;
        stall_cnt = 0;
        retire_q.delete();
        for (int c = 0; c < n; c++) step();
    endtask

    function automatic int pos_of(int id);
        foreach (retire_q[i]) if (retire_q[i] == id) return i;
        return -100;
    endfunction

    // Number of retirement slots between two ids; -1 if any of them is not a no-op.
    function automatic int gap_between(int a, int b);
        int pa, pb;
        pa = pos_of(a);
        pb = pos_of(b);
        if (pa < 0 || pb <= pa) return -1;
        for (int i = pa + 1; i < pb; i++) if (retire_q[i] != -1) return -1;
        return pb - pa - 1;
    endfunction

    task automatic poke_idle();
        @(negedge clk);
        dec_src_vld = '0; dec_src_idx = '0;
        stg_vld = '0; stg_wen = '0; stg_dst = '0;
        br_vld = 1'b0; br_taken = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset and idle state (R4).
        repeat (3) @(posedge clk);
        #1;
        chk("R4 idle hold_front", hold_front, 1'b0);
        chk("R4 idle redirect", redirect, 1'b0);
        chk("R4 idle squash_fetch", squash_fetch, 1'b0);
        rst = 1'b0;

        // Directed R4: producer without write enable, invalid slot, invalid source.
        poke_idle();
        dec_src_vld = 2'b01; dec_src_idx[0] = 5'd3;
        stg_vld = 3'b001; stg_wen = 3'b000; stg_dst[0] = 5'd3;
        #1 chk("R4 no-write producer", hold_front, 1'b0);
        stg_vld = 3'b000; stg_wen = 3'b100; stg_dst[2] = 5'd3;
        #1 chk("R4 invalid slot", hold_front, 1'b0);
        dec_src_vld = 2'b00; stg_vld = 3'b100;
        #1 chk("R4 invalid source", hold_front, 1'b0);
        dec_src_vld = 2'b10; dec_src_idx[1] = 5'd3;
        #1 chk("R1 write-back match", hold_front, 1'b1);
        // Directed R3: register 0 against a register-0 writer.
        dec_src_vld = 2'b11; dec_src_idx = '0;
        stg_vld = 3'b111; stg_wen = 3'b111; stg_dst = '0;
        #1 chk("R3 zero source", hold_front, 1'b0);
        poke_idle();

        // R8: dependency distance 1..4.
        for (int d = 1; d <= 4; d++) begin
            clear_prog();
            set_ins(0, 1, 1, 6, 7, 0, 0);
            for (int j = 1; j < d; j++) set_ins(j, 1, 10 + j, 6, 7, 0, 0);
            set_ins(d, 1, 20, 7, 1, 0, 0);
            run_prog(16);
            chk_int($sformatf("R8 stalls at distance %0d", d), stall_cnt, (d < 4) ? 4 - d : 0);
        end

        // R8: independent sequence.
        clear_prog();
        for (int i = 0; i < 6; i++) set_ins(i, 1, 1 + i, 10 + i, 20 + i, 0, 0);
        run_prog(14);
        chk_int("R8 independent stalls", stall_cnt, 0);

        // R3: writer of register 0 followed by reader of register 0.
        clear_prog();
        set_ins(0, 1, 0, 5, 6, 0, 0);
        set_ins(1, 1, 2, 0, 0, 0, 0);
        run_prog(10);
        chk_int("R3 zero register stalls", stall_cnt, 0);

        // R9: taken branch leaves two no-op slots.
        clear_prog();
        set_ins(0, 1, 2, 5, 6, 0, 0);
        set_ins(1, 2, 0, 3, 4, 1, 5);
        set_ins(2, 1, 7, 8, 9, 0, 0);
        set_ins(3, 1, 8, 8, 9, 0, 0);
        set_ins(5, 1, 9, 10, 11, 0, 0);
        run_prog(14);
        chk_int("R9 slots after taken branch", gap_between(1, 5), 2);
        chk_int("R9 wrong path retired", pos_of(2), -100);

        // R7: not-taken branch costs nothing.
        clear_prog();
        set_ins(0, 2, 0, 3, 4, 0, 6);
        set_ins(1, 1, 7, 8, 9, 0, 0);
        run_prog(10);
        chk_int("R7 not-taken gap", gap_between(0, 1), 0);
        chk_int("R7 not-taken stalls", stall_cnt, 0);

        // R6: stalled reader in decode while a taken branch is in execute.
        clear_prog();
        set_ins(0, 1, 1, 5, 6, 0, 0);
        set_ins(1, 2, 0, 3, 4, 1, 4);
        set_ins(2, 1, 7, 1, 9, 0, 0);
        set_ins(4, 1, 8, 10, 11, 0, 0);
        run_prog(14);
        chk_int("R6 stalls under flush", stall_cnt, 0);
        chk_int("R6 slots after branch", gap_between(1, 4), 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule